// File: doc/BRIEF.md
# Periodic Interrupt Timer Bank

The block holds a set of independent down-counters behind a small synchronous register port. Each channel has a reload register, a readable live count, a control register and an event flag. After a channel is started, its count falls by one per clock. When the count is zero, the next step loads the reload value again, raises the channel's event flag and continues counting. The timer therefore produces an event every reload value + 1 cycles until software stops it. A global disable bit freezes every counter. A channel other than channel 0 can be linked to its lower neighbour. A linked channel steps only on its neighbour's wrap events, so two channels form one wide count.

Each channel runs a two-state controller. In CH_IDLE the count holds. The start transition goes from CH_IDLE to CH_RUN when the enable bit is set and the bank is not frozen, and it loads the count from the reload register. The stop transition goes from CH_RUN back to CH_IDLE when the enable bit is cleared, and the count stays where it is. A new reload value is only used at the next wrap or at the next start, so restarting a period means clearing enable and then setting it again. A channel's interrupt line is its flag gated by its interrupt-enable bit.

Top module: `periodic_timer_bank`

## Requirements
- R1: After reset every register reads zero except the bank control register, which reads 0x2 (disable set). While the bank is disabled, no counter loads or counts, even with enable set.
- R2: Address map (byte addresses, 32-bit words): 0x000 is the bank control register, with bit 1 as the freeze/disable bit. Channel n occupies 0x100 + 0x10*n, with reload at +0x0, live count at +0x4, control at +0x8 and flag at +0xC. The live count is read-only and writes to it are ignored. Any other address reads 0.
- R3: Control bit 0 is enable. On the first clock edge at which enable is seen set in CH_IDLE, the count is loaded from the reload value. After that it drops by one per clock.
- R4: When the count is 0, the next step reloads it from the reload value and sets flag bit 0, and counting continues. The first flag appears reload+2 edges after the edge that writes enable, and later events follow every reload+1 edges.
- R5: Writing the reload register while the channel runs leaves the live count unchanged. The new value is taken at the next wrap.
- R6: Clearing enable holds the count at its value. Setting enable again restarts from the reload value.
- R7: While bank bit 1 is set, all counts hold. Counting resumes one edge after the bit is cleared.
- R8: Writing 1 to flag bit 0 clears the flag, and writing 0 has no effect. If a clear arrives in the same cycle as a wrap event, the flag stays set.
- R9: irq[n] is high exactly when channel n's flag is set and its control bit 1 (interrupt enable) is set.
- R10: When control bit 2 is set on channel n > 0, that channel steps only in cycles where channel n-1 wraps. On channel 0, bit 2 is stored but has no effect.
- R11: A read of the live count returns the current value of the counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
The periodic behaviour is tried with reload values of 1, 2, 6 and 13 on different channels. A wrong period length, an off-by-one in the first period, or a wrong channel decode each shows up as a mismatch at a known edge. A reload write during a running period tells apart a design that restarts the count from one that keeps it. Cleared-then-set enable, a bank freeze and a linked pair check where counting is held, resumed or slaved to a neighbour. A clear timed onto a wrap edge checks that a simultaneous event is not lost.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic link;   // bit 2: step on lower neighbour's wrap
        logic tie;    // bit 1: interrupt enable
        logic en;     // bit 0: run
    } ch_ctrl_t;

    localparam logic [1:0] OFF_RELOAD = 2'd0;
    localparam logic [1:0] OFF_COUNT  = 2'd1;
    localparam logic [1:0] OFF_CTRL   = 2'd2;
    localparam logic [1:0] OFF_FLAG   = 2'd3;
    localparam int         FRZ_BIT    = 1;
endpackage

// File: rtl/ptmr_decode.sv
module ptmr_decode #(
    parameter int AW  = 12,
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           we,
    input  logic [AW-1:0]  addr,
    output logic           bank_we,
    output logic [NCH-1:0] reload_we,
    output logic [NCH-1:0] ctrl_we,
    output logic [NCH-1:0] flag_we,
    output logic           hit_bank,
    output logic           hit_ch,
    output logic [IW-1:0]  ch_idx,
    output logic [1:0]     reg_off
);
    import ptmr_pkg::*;

    always_comb begin
        hit_bank = (addr == '0);
        hit_ch   = (addr[AW-1:8] == (AW-8)'(1)) && (addr[1:0] == 2'b00)
                   && (int'(addr[7:4]) < NCH);
        ch_idx   = addr[4 +: IW];
        reg_off  = addr[3:2];
        bank_we  = we && hit_bank;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_strobe
        logic sel;
        assign sel          = we && hit_ch && (int'(ch_idx) == i);
        assign reload_we[i] = sel && (reg_off == OFF_RELOAD);
        assign ctrl_we[i]   = sel && (reg_off == OFF_CTRL);
        assign flag_we[i]   = sel && (reg_off == OFF_FLAG);
    end
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel #(
    parameter int W         = 32,
    parameter bit CAN_CHAIN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frz,
    input  logic               reload_we,
    input  logic               ctrl_we,
    input  logic               flag_we,
    input  logic [W-1:0]       wdata,
    input  logic               chain_in,
    output logic               wrap,
    output logic [W-1:0]       count,
    output logic [W-1:0]       reload,
    output ptmr_pkg::ch_ctrl_t ctrl,
    output logic               flag,
    output logic               irq
);
    import ptmr_pkg::*;

    ch_state_e st_q, st_d;
    logic [W-1:0] cnt_q, cnt_d, rl_q;
    ch_ctrl_t ctrl_q;
    logic flag_q, flag_d;
    logic linked, step;

    assign linked = CAN_CHAIN && ctrl_q.link;
    assign step   = !frz && (linked ? chain_in : 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CH_IDLE;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    // software-written registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rl_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (reload_we) rl_q <= wdata;
            if (ctrl_we)   ctrl_q <= ch_ctrl_t'(wdata[2:0]);
        end
    end

    // next state and outputs
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        wrap  = 1'b0;
        unique case (st_q)
            CH_IDLE: begin
                if (ctrl_q.en && !frz) begin
                    st_d  = CH_RUN;
                    cnt_d = rl_q;
                end
            end
            CH_RUN: begin
                if (!ctrl_q.en) begin
                    st_d = CH_IDLE;
                end else if (step) begin
                    if (cnt_q == '0) begin
                        wrap  = 1'b1;
                        cnt_d = rl_q;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: st_d = CH_IDLE;
        endcase
        if (wrap)                     flag_d = 1'b1;
        else if (flag_we && wdata[0]) flag_d = 1'b0;
        else                          flag_d = flag_q;
    end

    assign count  = cnt_q;
    assign reload = rl_q;
    assign ctrl   = ctrl_q;
    assign flag   = flag_q;
    assign irq    = flag_q && ctrl_q.tie;

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN && ctrl_q.en && step && cnt_q != '0)
        |=> cnt_q == $past(cnt_q) - 1'b1);
    assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN && ctrl_q.en && step && cnt_q == '0)
        |=> (cnt_q == $past(rl_q)) && flag_q);
    assert_reload_write_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_we && st_q == CH_RUN && !step) |=> $stable(cnt_q));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_IDLE && !ctrl_q.en) |=> $stable(cnt_q));
    assert_clear_loses_to_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && flag_we && wdata[0]) |=> flag_q);
    assert_linked_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN && linked && !chain_in) |=> $stable(cnt_q));
endmodule

// File: rtl/periodic_timer_bank.sv
module periodic_timer_bank #(
    parameter int AW  = 12,
    parameter int DW  = 32,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    import ptmr_pkg::*;

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic           frz_q;
    logic           bank_we, hit_bank, hit_ch;
    logic [NCH-1:0] reload_we, ctrl_we, flag_we, wrap, flag;
    logic [IW-1:0]  ch_idx;
    logic [1:0]     reg_off;
    logic [DW-1:0]  count_a  [NCH];
    logic [DW-1:0]  reload_a [NCH];
    ch_ctrl_t       ctrl_a   [NCH];

    ptmr_decode #(.AW(AW), .NCH(NCH)) u_decode (
        .we        (bus_we),
        .addr      (bus_addr),
        .bank_we   (bank_we),
        .reload_we (reload_we),
        .ctrl_we   (ctrl_we),
        .flag_we   (flag_we),
        .hit_bank  (hit_bank),
        .hit_ch    (hit_ch),
        .ch_idx    (ch_idx),
        .reg_off   (reg_off)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       frz_q <= 1'b1;
        else if (bank_we) frz_q <= bus_wdata[FRZ_BIT];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic chain_src;
        if (i == 0) begin : g_first
            assign chain_src = 1'b0;
        end else begin : g_rest
            assign chain_src = wrap[i-1];
        end

        ptmr_channel #(.W(DW), .CAN_CHAIN(i != 0)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .frz       (frz_q),
            .reload_we (reload_we[i]),
            .ctrl_we   (ctrl_we[i]),
            .flag_we   (flag_we[i]),
            .wdata     (bus_wdata),
            .chain_in  (chain_src),
            .wrap      (wrap[i]),
            .count     (count_a[i]),
            .reload    (reload_a[i]),
            .ctrl      (ctrl_a[i]),
            .flag      (flag[i]),
            .irq       (irq[i])
        );

        assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            frz_q |=> $stable(count_a[i]));
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_bank) begin
            bus_rdata[FRZ_BIT] = frz_q;
        end else if (hit_ch) begin
            unique case (reg_off)
                OFF_RELOAD: bus_rdata = reload_a[ch_idx];
                OFF_COUNT:  bus_rdata = count_a[ch_idx];
                OFF_CTRL:   bus_rdata = DW'(ctrl_a[ch_idx]);
                OFF_FLAG:   bus_rdata = DW'(flag[ch_idx]);
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: tb/periodic_timer_bank_bench.sv
module periodic_timer_bank_bench;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    periodic_timer_bank u_periodic_timer_bank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {channel, reload}
    localparam logic [35:0] VEC [0:3] = '{
        {4'd0, 32'd1}, {4'd1, 32'd6}, {4'd2, 32'd13}, {4'd3, 32'd2}
    };

    function automatic logic [11:0] ra(int ch, int off);
        return 12'(32'h100 + 16 * ch + off);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk_reg("R1 bank ctrl", 12'h000, 32'h2);
        for (int c = 0; c < NCH; c++) begin
            chk_reg("R1 reload", ra(c, 0), 0);
            chk_reg("R1 count", ra(c, 4), 0);
            chk_reg("R1 ctrl", ra(c, 8), 0);
            chk_reg("R1 flag", ra(c, 12), 0);
        end
        chk("R1 irq", 32'(irq), 0);
        chk_reg("R2 unmapped", 12'h004, 0);
        chk_reg("R2 unmapped ch", 12'h140, 0);

        // R1 disabled bank does not load
        wr(ra(0, 0), 32'd5);
        wr(ra(0, 8), 32'h1);
        cyc(3);
        chk_reg("R1 no load while disabled", ra(0, 4), 0);
        wr(12'h000, 32'h0);
        cyc(1);
        chk_reg("R7 resume loads", ra(0, 4), 5);
        wr(ra(0, 8), 32'h0);

        // R3 R4 R9 table walk
        for (int k = 0; k < 4; k++) begin
            int ch;
            logic [31:0] l;
            ch = int'(VEC[k][35:32]);
            l  = VEC[k][31:0];
            wr(ra(ch, 0), l);
            wr(ra(ch, 8), 32'h3);
            cyc(1);
            chk_reg("R3 loaded", ra(ch, 4), l);
            cyc(int'(l));
            chk_reg("R11 count at zero", ra(ch, 4), 0);
            chk_reg("R4 no flag yet", ra(ch, 12), 0);
            chk("R9 irq low", 32'(irq[ch]), 0);
            cyc(1);
            chk_reg("R4 flag set", ra(ch, 12), 1);
            chk_reg("R4 reloaded", ra(ch, 4), l);
            chk("R9 irq high", 32'(irq[ch]), 1);
            cyc(int'(l) + 1);
            chk_reg("R4 periodic", ra(ch, 4), l);
            wr(ra(ch, 12), 32'h1);
            chk_reg("R8 cleared", ra(ch, 12), 0);
            wr(ra(ch, 8), 32'h0);
        end

        // R5 reload write during run
        wr(ra(2, 0), 32'd10);
        wr(ra(2, 8), 32'h1);
        cyc(1);
        chk_reg("R5 start", ra(2, 4), 10);
        wr(ra(2, 0), 32'd3);
        chk_reg("R5 count kept", ra(2, 4), 9);
        cyc(9);
        chk_reg("R5 old period", ra(2, 4), 0);
        cyc(1);
        chk_reg("R5 new reload used", ra(2, 4), 3);
        chk_reg("R4 flag", ra(2, 12), 1);

        // R8 flag clear rules
        wr(ra(2, 12), 32'h0);
        chk_reg("R8 write 0 ignored", ra(2, 12), 1);
        wr(ra(2, 12), 32'h1);
        chk_reg("R8 write 1 clears", ra(2, 12), 0);
        cyc(1);
        wr(ra(2, 12), 32'h1);
        chk_reg("R8 set wins", ra(2, 12), 1);
        chk_reg("R8 wrap reload", ra(2, 4), 3);

        // R6 disable hold and restart
        wr(ra(2, 8), 32'h0);
        chk_reg("R6 after stop", ra(2, 4), 2);
        cyc(3);
        chk_reg("R6 held", ra(2, 4), 2);
        wr(ra(2, 8), 32'h1);
        cyc(1);
        chk_reg("R6 restart", ra(2, 4), 3);

        // R7 bank freeze
        wr(12'h000, 32'h2);
        chk_reg("R7 frozen", ra(2, 4), 2);
        cyc(3);
        chk_reg("R7 still frozen", ra(2, 4), 2);
        wr(12'h000, 32'h0);
        chk_reg("R7 unfreeze edge", ra(2, 4), 2);
        cyc(1);
        chk_reg("R7 counting", ra(2, 4), 1);
        wr(ra(2, 8), 32'h0);
        wr(ra(2, 12), 32'h1);

        // R10 linked pair, ch0 link bit ignored
        wr(ra(1, 0), 32'd2);
        wr(ra(1, 8), 32'h5);
        wr(ra(0, 0), 32'd1);
        wr(ra(0, 8), 32'h5);
        cyc(2);
        chk_reg("R10 upper waits", ra(1, 4), 2);
        cyc(1);
        chk_reg("R10 upper steps", ra(1, 4), 1);
        chk_reg("R10 ch0 free running", ra(0, 4), 1);
        cyc(2);
        chk_reg("R10 upper zero", ra(1, 4), 0);
        chk_reg("R10 no flag yet", ra(1, 12), 0);
        cyc(2);
        chk_reg("R10 upper wraps", ra(1, 12), 1);
        chk_reg("R10 upper reload", ra(1, 4), 2);
        chk("R9 irq gated", 32'(irq[1]), 0);
        wr(ra(1, 4), 32'h55);
        chk_reg("R2 count write ignored", ra(1, 4), 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule